// File: doc/BRIEF.md
# Coarse Frequency-Lock Accumulator

This block performs the integer frequency acquisition of a burst-mode all-digital PLL. In each burst the oscillator runs for one reference period. A synchronous edge counter, enabled only for that window, counts the oscillator's rising edges, which reach the counter as one-cycle edge pulses. After the oscillator stops, the sequencer raises an update strobe. On that strobe the count is subtracted from a programmable frequency control word, the difference is limited to a maximum step, and the result is added into a saturating coarse control accumulator. The accumulator drives the 7-bit coarse bank of the oscillator control word.

The accumulator keeps its value through idle periods, so the frequency found in one burst carries over into the next. Before the first burst it can be preloaded with an estimated word. When the count equals the control word the error is exactly zero and the coarse word stays where it is. The loop therefore locks where the oscillator frequency equals the control word times the reference frequency.

Top module: `coarse_lock_loop`

## Requirements
- R1: After an asynchronous reset, `coarse_o` equals `ACC_RST` (default 64) and `cnt_o` is 0.
- R2: `cnt_o` increases by one on each clock edge where `win_en_i` and `edge_i` are both high. It is unchanged when either of them is low.
- R3: `win_clr_i` sets `cnt_o` to 0 on the next edge. The clear wins over counting in the same cycle.
- R4: `cnt_o` saturates at 255 (all ones of `CNT_W`=8 bits) and does not wrap.
- R5: `err_o` is a two's-complement 9-bit value equal to `fcw_i - cnt_o`, limited to the range -`STEP_MAX`..+`STEP_MAX` (default 16). It follows its inputs combinationally.
- R6: When `cnt_o == fcw_i`, `err_o` is 0, and an update strobe leaves `coarse_o` unchanged.
- R7: On a clock edge with `upd_i` high and `preload_i` low, `coarse_o` becomes `coarse_o + err_o`, saturated to the range 0..127.
- R8: With `upd_i` and `preload_i` both low, `coarse_o` holds its value for any number of cycles.
- R9: On a clock edge with `preload_i` high, `coarse_o` takes `preload_val_i`. This holds even when `upd_i` is high in the same cycle.
- R10: Starting from a preloaded word far below lock, repeated bursts drive the count to `fcw_i`, after which `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcw_i | input | 8 | Frequency control word (target edges per window) |
| edge_i | input | 1 | One oscillator rising-edge pulse per cycle |
| win_en_i | input | 1 | Counting window enable |
| win_clr_i | input | 1 | Clear edge counter before a window |
| upd_i | input | 1 | One-cycle update strobe after the window |
| preload_i | input | 1 | Load accumulator with the estimate |
| preload_val_i | input | 7 | Estimated starting coarse word |
| cnt_o | output | 8 | Edge count of the current window |
| err_o | output | 9 | Limited signed frequency error |
| coarse_o | output | 7 | Coarse oscillator control word |

## Verification
The preload and the update strobe can both arrive on the same clock edge. The bench makes this happen by raising both in one cycle while the count is well away from the control word, so that a nonzero error is present. It then checks that `coarse_o` equals the preload value and not the sum. A second collision occurs inside the counter, where a clear and a counted edge share a cycle. The bench asserts clear, enable and edge together and checks that the count reads zero.

// File: rtl/coarse_lock_pkg.sv
package coarse_lock_pkg;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/cl_edge_counter.sv
module cl_edge_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  // clear wins; saturate so an overrange window cannot alias low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (clr_i)                               cnt_q <= '0;
    else if (en_i && edge_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cl_err_map.sv
module cl_err_map
  import coarse_lock_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int STEP_MAX = 16,
  localparam int ERR_W   = CNT_W + 1
) (
  input  logic [CNT_W-1:0] fcw_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [ERR_W-1:0] err_o
);
  always_comb begin
    int diff;
    diff  = int'(fcw_i) - int'(cnt_i);
    err_o = ERR_W'(clamp_int(diff, -STEP_MAX, STEP_MAX));
  end
endmodule

// File: rtl/cl_accum.sv
module cl_accum
  import coarse_lock_pkg::*;
#(
  parameter int CW_W    = 7,
  parameter int ERR_W   = 9,
  parameter int ACC_RST = 64,
  localparam int ACC_MAX = (1 << CW_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preload_i,
  input  logic [CW_W-1:0]  preload_val_i,
  input  logic             upd_i,
  input  logic [ERR_W-1:0] err_i,
  output logic [CW_W-1:0]  acc_o
);
  logic [CW_W-1:0] acc_q, acc_sum;

  always_comb begin
    int s;
    s       = int'(acc_q) + int'($signed(err_i));
    acc_sum = CW_W'(clamp_int(s, 0, ACC_MAX));
  end

  // preload has priority over the burst update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= CW_W'(ACC_RST);
    else if (preload_i) acc_q <= preload_val_i;
    else if (upd_i)     acc_q <= acc_sum;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/coarse_lock_loop.sv
module coarse_lock_loop #(
  parameter int CNT_W    = 8,
  parameter int CW_W     = 7,
  parameter int STEP_MAX = 16,
  parameter int ACC_RST  = 64,
  localparam int ERR_W   = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fcw_i,
  input  logic             edge_i,
  input  logic             win_en_i,
  input  logic             win_clr_i,
  input  logic             upd_i,
  input  logic             preload_i,
  input  logic [CW_W-1:0]  preload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [ERR_W-1:0] err_o,
  output logic [CW_W-1:0]  coarse_o
);
  logic [CNT_W-1:0] cnt;
  logic [ERR_W-1:0] err;

  cl_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (win_clr_i),
    .en_i   (win_en_i),
    .edge_i (edge_i),
    .cnt_o  (cnt)
  );

  cl_err_map #(.CNT_W(CNT_W), .STEP_MAX(STEP_MAX)) u_err (
    .fcw_i (fcw_i),
    .cnt_i (cnt),
    .err_o (err)
  );

  cl_accum #(.CW_W(CW_W), .ERR_W(ERR_W), .ACC_RST(ACC_RST)) u_acc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .preload_i     (preload_i),
    .preload_val_i (preload_val_i),
    .upd_i         (upd_i),
    .err_i         (err),
    .acc_o         (coarse_o)
  );

  assign cnt_o = cnt;
  assign err_o = err;
endmodule

// File: rtl/coarse_lock_loop_chk.sv
module coarse_lock_loop_chk #(
  parameter int CNT_W    = 8,
  parameter int CW_W     = 7,
  parameter int STEP_MAX = 16,
  localparam int ERR_W   = CNT_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] fcw_i,
  input logic             win_clr_i,
  input logic             upd_i,
  input logic             preload_i,
  input logic [CW_W-1:0]  preload_val_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [ERR_W-1:0] err_o,
  input logic [CW_W-1:0]  coarse_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_clr_i |=> cnt_o == '0); // R3

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1)); // R2

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_clr_i && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX); // R4

  AST_ERR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(err_o) <= STEP_MAX) && ($signed(err_o) >= -STEP_MAX)); // R5

  AST_MATCH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == fcw_i) |-> err_o == '0); // R6

  AST_MATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !preload_i && cnt_o == fcw_i) |=> $stable(coarse_o)); // R6

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !preload_i) |=> $stable(coarse_o)); // R8

  AST_PRELOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_i |=> coarse_o == $past(preload_val_i)); // R9
endmodule

bind coarse_lock_loop coarse_lock_loop_chk #(
  .CNT_W(CNT_W), .CW_W(CW_W), .STEP_MAX(STEP_MAX)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fcw_i         (fcw_i),
  .win_clr_i     (win_clr_i),
  .upd_i         (upd_i),
  .preload_i     (preload_i),
  .preload_val_i (preload_val_i),
  .cnt_o         (cnt_o),
  .err_o         (err_o),
  .coarse_o      (coarse_o)
);

// File: tb/coarse_lock_loop_test.sv
module coarse_lock_loop_test;
  localparam int STEP = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] fcw_i = 8'd50;
  logic       edge_i = 1'b0, win_en_i = 1'b0, win_clr_i = 1'b0;
  logic       upd_i = 1'b0, preload_i = 1'b0;
  logic [6:0] preload_val_i = '0;
  logic [7:0] cnt_o;
  logic [8:0] err_o;
  logic [6:0] coarse_o;

  int checks = 0, fails = 0;
  int exp_c = 64;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  coarse_lock_loop uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fcw_i(fcw_i), .edge_i(edge_i),
    .win_en_i(win_en_i), .win_clr_i(win_clr_i), .upd_i(upd_i),
    .preload_i(preload_i), .preload_val_i(preload_val_i),
    .cnt_o(cnt_o), .err_o(err_o), .coarse_o(coarse_o)
  );

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  // clear, count n edges, leave window closed
  task automatic run_window(int n);
    win_clr_i = 1'b1; step();
    win_clr_i = 1'b0;
    if (n > 0) begin
      win_en_i = 1'b1; edge_i = 1'b1; step(n);
    end
    win_en_i = 1'b0; edge_i = 1'b0;
  endtask

  task automatic do_update();
    upd_i = 1'b1; step(); upd_i = 1'b0;
  endtask

  task automatic do_preload(int v);
    preload_val_i = 7'(v); preload_i = 1'b1; step(); preload_i = 1'b0;
    exp_c = v;
  endtask

  task automatic t_reset();
    step();
    check("R1 coarse", int'(coarse_o), 64);
    check("R1 cnt", int'(cnt_o), 0);
    rst_ni = 1'b1; step();
    check("R1 coarse after release", int'(coarse_o), 64);
  endtask

  task automatic t_count_gate();
    run_window(7);
    check("R2 count", int'(cnt_o), 7);
    win_en_i = 1'b0; edge_i = 1'b1; step(3);
    check("R2 no en", int'(cnt_o), 7);
    win_en_i = 1'b1; edge_i = 1'b0; step(3);
    check("R2 no edge", int'(cnt_o), 7);
    win_en_i = 1'b0;
    check("R8 idle hold", int'(coarse_o), exp_c);
  endtask

  task automatic t_clear_collide();
    run_window(5);
    win_clr_i = 1'b1; win_en_i = 1'b1; edge_i = 1'b1; step();
    win_clr_i = 1'b0; win_en_i = 1'b0; edge_i = 1'b0;
    check("R3 clear beats count", int'(cnt_o), 0);
  endtask

  task automatic t_burst(int n, string req);
    int e;
    run_window(n);
    e = clampi(int'(fcw_i) - clampi(n, 0, 255), -STEP, STEP);
    check({req, " err"}, int'($signed(err_o)), e);
    do_update();
    exp_c = clampi(exp_c + e, 0, 127);
    check({req, " coarse"}, int'(coarse_o), exp_c);
  endtask

  task automatic t_counter_sat();
    run_window(300);
    check("R4 cnt sat", int'(cnt_o), 255);
    check("R5 err low limit", int'($signed(err_o)), -STEP);
  endtask

  task automatic t_match();
    run_window(50);
    check("R6 err zero", int'($signed(err_o)), 0);
    do_update();
    check("R6 coarse held", int'(coarse_o), exp_c);
  endtask

  task automatic t_idle();
    step(40);
    check("R8 long idle", int'(coarse_o), exp_c);
  endtask

  task automatic t_preload_collide();
    do_preload(10);
    check("R9 preload", int'(coarse_o), 10);
    run_window(30);
    preload_val_i = 7'd99; preload_i = 1'b1; upd_i = 1'b1; step();
    preload_i = 1'b0; upd_i = 1'b0; exp_c = 99;
    check("R9 preload beats update", int'(coarse_o), 99);
  endtask

  task automatic t_acc_sat();
    do_preload(120);
    t_burst(30, "R7 sat high");
    check("R7 top", int'(coarse_o), 127);
    do_preload(5);
    t_burst(80, "R7 sat low");
    check("R7 bottom", int'(coarse_o), 0);
  endtask

  // bench oscillator model: edges per window = coarse/2 + 10, lock at 80
  task automatic t_lock();
    do_preload(20);
    for (int b = 0; b < 20; b++) begin
      run_window(int'(coarse_o) / 2 + 10);
      do_update();
    end
    run_window(int'(coarse_o) / 2 + 10);
    check("R10 locked count", int'(cnt_o), 50);
    check("R10 locked err", int'($signed(err_o)), 0);
    check("R10 locked coarse", int'(coarse_o), 80);
  endtask

  initial begin
    t_reset();
    t_count_gate();
    t_clear_collide();
    t_burst(30, "R7 up");
    t_burst(60, "R7 down");
    t_burst(45, "R5 small");
    t_counter_sat();
    do_update(); exp_c = clampi(exp_c - STEP, 0, 127);
    check("R7 limited step", int'(coarse_o), exp_c);
    t_match();
    t_idle();
    t_preload_collide();
    t_acc_sat();
    t_lock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule